// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block sequences a multi-cycle processor datapath that has one shared instruction/data memory and one ALU. A twelve-state Moore machine moves one instruction at a time through the steps it needs: fetch, decode, then an execution path of its own. Each path ends by returning to fetch. Every cycle, the block drives the datapath's register enables and multiplexer selects. An ALU decoder turns the ALU operation class of the current state, plus the function field of the instruction, into a 3-bit ALU control word.

The datapath presents the opcode and function fields of its instruction register. These fields must stay stable from the end of fetch until the instruction returns to fetch. The ALU itself does the PC increment during fetch and computes the branch target during decode. This is why no separate adders are needed. Instruction classes take different numbers of cycles:

| Class | Cycles |
|---|---|
| Jump, branch-if-equal | 3 |
| Register-register ALU, store, add-immediate | 4 |
| Load | 5 |
| Unrecognised opcode | 2 |

Top module: `mcc_ctrl_top`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, and in the first cycle after it is released, the outputs show the fetch step.
- R2: The fetch step asserts pcWrite and irWrite, sets aluSrcB=01, and drives iOrD=0, aluSrcA=0, pcSrc=00 and aluCtl=010 (add). It is always followed by decode.
- R3: The decode step sets aluSrcB=11, with aluSrcA=0 and aluCtl=010. At the end of decode, the block dispatches on the opcode: 100011 is load, 101011 is store, 000000 is register-register, 000100 is branch-if-equal, 001000 is add-immediate and 000010 is jump.
- R4: A load runs decode, then an address step (aluSrcA=1, aluSrcB=10, aluCtl=010), then a read step (iOrD=1), then a writeback step (regWrite=1, memToReg=1, regDst=0), then fetch. This is 5 cycles in all.
- R5: A store runs decode, then the address step, then a write step (memWrite=1, iOrD=1), then fetch. This is 4 cycles in all.
- R6: A register-register instruction runs decode, then an execute step (aluSrcA=1, aluSrcB=00, aluCtl from the function field), then a writeback step (regWrite=1, regDst=1, memToReg=0), then fetch. This is 4 cycles in all.
- R7: A branch-if-equal runs decode, then a branch step (branch=1, aluSrcA=1, aluSrcB=00, pcSrc=01, aluCtl=110 subtract), then fetch. This is 3 cycles in all.
- R8: An add-immediate runs decode, then an execute step (aluSrcA=1, aluSrcB=10, aluCtl=010), then a writeback step (regWrite=1, regDst=0, memToReg=0), then fetch. This is 4 cycles in all.
- R9: A jump runs decode, then a jump step (pcWrite=1, pcSrc=10), then fetch. This is 3 cycles in all.
- R10: Any other opcode returns from decode directly to fetch. No register or memory write happens.
- R11: In the register-register execute step, the function field sets aluCtl as follows:

  | Function field | Operation | aluCtl |
  |---|---|---|
  | 100000 | add | 010 |
  | 100010 | subtract | 110 |
  | 100100 | and | 000 |
  | 100101 | or | 001 |
  | 101010 | set-less-than | 111 |
  | any other code | add | 010 |

  Every state with no ALU use drives aluCtl=010.
- R12: In every step, each enable and select not named for that step is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| pcWrite | output | 1 | Unconditional program counter write |
| irWrite | output | 1 | Instruction register load |
| regWrite | output | 1 | Register file write |
| memWrite | output | 1 | Memory write |
| branch | output | 1 | Conditional program counter write when the ALU result is zero |
| iOrD | output | 1 | Memory address select: 0 = program counter, 1 = ALU output register |
| aluSrcA | output | 1 | ALU A select: 0 = program counter, 1 = register A |
| aluSrcB | output | 2 | ALU B select: 00 = register B, 01 = constant 4, 10 = immediate, 11 = immediate shifted left by 2 |
| pcSrc | output | 2 | Next program counter select: 00 = ALU result, 01 = ALU output register, 10 = jump target |
| regDst | output | 1 | Destination register select: 0 = rt field, 1 = rd field |
| memToReg | output | 1 | Writeback data select: 0 = ALU output, 1 = memory data |
| aluCtl | output | 3 | ALU operation code |

## Verification
The bench builds the block with its default 6-bit opcode and function widths. At this size, every one of the 64 opcodes can be run as a full instruction, and for the register-register opcode all 64 function codes are swept through the execute step. At each cycle of every path, the bench compares the whole output vector against a step table derived from the requirements. This covers the cycle count of each class, the return to fetch, and the zero level of every unnamed strobe. A reset applied in the middle of a load checks the synchronous return to fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OpW     = 6;
  localparam int FnW     = 6;
  localparam int SelW    = 2;
  localparam int AluOpW  = 2;
  localparam int AluCtlW = 3;
  localparam int StW     = 4;

  // opcode values
  localparam logic [OpW-1:0] OpLoad  = 6'b100011;
  localparam logic [OpW-1:0] OpStore = 6'b101011;
  localparam logic [OpW-1:0] OpReg   = 6'b000000;
  localparam logic [OpW-1:0] OpBeq   = 6'b000100;
  localparam logic [OpW-1:0] OpAddi  = 6'b001000;
  localparam logic [OpW-1:0] OpJump  = 6'b000010;

  // function field values
  localparam logic [FnW-1:0] FnAdd = 6'b100000;
  localparam logic [FnW-1:0] FnSub = 6'b100010;
  localparam logic [FnW-1:0] FnAnd = 6'b100100;
  localparam logic [FnW-1:0] FnOr  = 6'b100101;
  localparam logic [FnW-1:0] FnSlt = 6'b101010;

  // ALU operation classes
  localparam logic [AluOpW-1:0] AopAdd   = 2'b00;
  localparam logic [AluOpW-1:0] AopSub   = 2'b01;
  localparam logic [AluOpW-1:0] AopFunct = 2'b10;

  // ALU control words
  localparam logic [AluCtlW-1:0] AluAnd = 3'b000;
  localparam logic [AluCtlW-1:0] AluOr  = 3'b001;
  localparam logic [AluCtlW-1:0] AluAdd = 3'b010;
  localparam logic [AluCtlW-1:0] AluSub = 3'b110;
  localparam logic [AluCtlW-1:0] AluSlt = 3'b111;

  typedef enum logic [StW-1:0] {
    StFetch  = 4'd0,
    StDecode = 4'd1,
    StMemAdr = 4'd2,
    StMemRd  = 4'd3,
    StMemWb  = 4'd4,
    StMemWr  = 4'd5,
    StExec   = 4'd6,
    StAluWb  = 4'd7,
    StBranch = 4'd8,
    StImmEx  = 4'd9,
    StImmWb  = 4'd10,
    StJump   = 4'd11
  } stateT;

  typedef struct packed {
    logic            pcWrite;
    logic            irWrite;
    logic            regWrite;
    logic            memWrite;
    logic            branch;
    logic            iOrD;
    logic            aluSrcA;
    logic [SelW-1:0] aluSrcB;
    logic [SelW-1:0] pcSrc;
    logic            regDst;
    logic            memToReg;
    logic [AluOpW-1:0] aluOp;
  } strobeT;

endpackage

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
#(
  parameter int OP_W = OpW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output stateT           state
);

  stateT nextState;

  always_comb begin
    nextState = StFetch;
    case (state)
      StFetch:  nextState = StDecode;
      StDecode: begin
        case (opcode)
          OpLoad, OpStore: nextState = StMemAdr;
          OpReg:           nextState = StExec;
          OpBeq:           nextState = StBranch;
          OpAddi:          nextState = StImmEx;
          OpJump:          nextState = StJump;
          default:         nextState = StFetch;
        endcase
      end
      StMemAdr: begin
        if (opcode == OpLoad)       nextState = StMemRd;
        else if (opcode == OpStore) nextState = StMemWr;
        else                        nextState = StFetch;
      end
      StMemRd:  nextState = StMemWb;
      StExec:   nextState = StAluWb;
      StImmEx:  nextState = StImmWb;
      default:  nextState = StFetch;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= StFetch;
    else     state <= nextState;
  end

endmodule

// File: rtl/mcc_strobes.sv
module mcc_strobes
  import mcc_pkg::*;
(
  input  stateT  state,
  output strobeT strobes
);

  always_comb begin
    strobes = '0;
    case (state)
      StFetch: begin
        strobes.pcWrite = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.aluSrcB = 2'b01;
        strobes.aluOp   = AopAdd;
      end
      StDecode: begin
        strobes.aluSrcB = 2'b11;
        strobes.aluOp   = AopAdd;
      end
      StMemAdr, StImmEx: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = 2'b10;
        strobes.aluOp   = AopAdd;
      end
      StMemRd: strobes.iOrD = 1'b1;
      StMemWb: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      StMemWr: begin
        strobes.iOrD     = 1'b1;
        strobes.memWrite = 1'b1;
      end
      StExec: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = 2'b00;
        strobes.aluOp   = AopFunct;
      end
      StAluWb: begin
        strobes.regWrite = 1'b1;
        strobes.regDst   = 1'b1;
      end
      StBranch: begin
        strobes.branch  = 1'b1;
        strobes.aluSrcA = 1'b1;
        strobes.pcSrc   = 2'b01;
        strobes.aluOp   = AopSub;
      end
      StImmWb: strobes.regWrite = 1'b1;
      StJump: begin
        strobes.pcWrite = 1'b1;
        strobes.pcSrc   = 2'b10;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcc_alu_decode.sv
module mcc_alu_decode
  import mcc_pkg::*;
#(
  parameter int FN_W = FnW
) (
  input  logic [AluOpW-1:0]  aluOp,
  input  logic [FN_W-1:0]    funct,
  output logic [AluCtlW-1:0] aluCtl
);

  logic [AluCtlW-1:0] functCtl;

  always_comb begin
    case (funct)
      FnAdd:   functCtl = AluAdd;
      FnSub:   functCtl = AluSub;
      FnAnd:   functCtl = AluAnd;
      FnOr:    functCtl = AluOr;
      FnSlt:   functCtl = AluSlt;
      default: functCtl = AluAdd;
    endcase
  end

  always_comb begin
    case (aluOp)
      AopSub:   aluCtl = AluSub;
      AopFunct: aluCtl = functCtl;
      default:  aluCtl = AluAdd;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_top.sv
module mcc_ctrl_top
  import mcc_pkg::*;
#(
  parameter int OP_W = OpW,
  parameter int FN_W = FnW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  input  logic [FN_W-1:0]    funct,
  output logic               pcWrite,
  output logic               irWrite,
  output logic               regWrite,
  output logic               memWrite,
  output logic               branch,
  output logic               iOrD,
  output logic               aluSrcA,
  output logic [SelW-1:0]    aluSrcB,
  output logic [SelW-1:0]    pcSrc,
  output logic               regDst,
  output logic               memToReg,
  output logic [AluCtlW-1:0] aluCtl
);

  stateT  state;
  strobeT strobes;

  mcc_sequencer #(.OP_W(OP_W)) uSeq (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .state  (state)
  );

  mcc_strobes uStb (
    .state   (state),
    .strobes (strobes)
  );

  mcc_alu_decode #(.FN_W(FN_W)) uAlu (
    .aluOp  (strobes.aluOp),
    .funct  (funct),
    .aluCtl (aluCtl)
  );

  assign pcWrite  = strobes.pcWrite;
  assign irWrite  = strobes.irWrite;
  assign regWrite = strobes.regWrite;
  assign memWrite = strobes.memWrite;
  assign branch   = strobes.branch;
  assign iOrD     = strobes.iOrD;
  assign aluSrcA  = strobes.aluSrcA;
  assign aluSrcB  = strobes.aluSrcB;
  assign pcSrc    = strobes.pcSrc;
  assign regDst   = strobes.regDst;
  assign memToReg = strobes.memToReg;

endmodule

// File: rtl/mcc_ctrl_checker.sv
module mcc_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       pcWrite,
  input logic       irWrite,
  input logic       regWrite,
  input logic       memWrite,
  input logic       branch,
  input logic       iOrD,
  input logic       aluSrcA,
  input logic [1:0] aluSrcB,
  input logic [1:0] pcSrc,
  input logic       regDst,
  input logic       memToReg,
  input logic [2:0] aluCtl
);

  assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irWrite && pcWrite && pcSrc == 2'b00 && aluSrcB == 2'b01));

  assert_fetch_leads_decode_R2: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (aluSrcB == 2'b11 && !aluSrcA && !pcWrite && !irWrite));

  assert_load_wb_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    (regWrite && memToReg) |-> $past(iOrD && !memWrite));

  assert_store_then_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> (irWrite && pcWrite));

  assert_reg_wb_after_exec_R6: assert property (@(posedge clk) disable iff (rst)
    (regWrite && regDst) |-> $past(aluSrcA && aluSrcB == 2'b00 && !branch));

  assert_branch_then_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    branch |=> (irWrite && pcWrite && pcSrc == 2'b00));

  assert_jump_then_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && pcSrc == 2'b10) |=> (irWrite && pcWrite && pcSrc == 2'b00));

  assert_branch_subtracts_R11: assert property (@(posedge clk) disable iff (rst)
    branch |-> aluCtl == 3'b110);

  assert_one_write_enable_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irWrite, regWrite, memWrite, branch}));

endmodule

bind mcc_ctrl_top mcc_ctrl_checker uChk (
  .clk      (clk),
  .rst      (rst),
  .pcWrite  (pcWrite),
  .irWrite  (irWrite),
  .regWrite (regWrite),
  .memWrite (memWrite),
  .branch   (branch),
  .iOrD     (iOrD),
  .aluSrcA  (aluSrcA),
  .aluSrcB  (aluSrcB),
  .pcSrc    (pcSrc),
  .regDst   (regDst),
  .memToReg (memToReg),
  .aluCtl   (aluCtl)
);

// File: tb/sim_mcc_ctrl_top.sv
`timescale 1ns/1ps
module sim_mcc_ctrl_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct = 6'd0;
  logic       pcWrite, irWrite, regWrite, memWrite, branch, iOrD, aluSrcA;
  logic [1:0] aluSrcB, pcSrc;
  logic       regDst, memToReg;
  logic [2:0] aluCtl;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mcc_ctrl_top u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .pcWrite(pcWrite), .irWrite(irWrite), .regWrite(regWrite),
    .memWrite(memWrite), .branch(branch), .iOrD(iOrD), .aluSrcA(aluSrcA),
    .aluSrcB(aluSrcB), .pcSrc(pcSrc), .regDst(regDst), .memToReg(memToReg),
    .aluCtl(aluCtl)
  );

  // step indices: 0 fetch, 1 decode, 2 load/store address, 3 read,
  // 4 load writeback, 5 store write, 6 reg execute, 7 reg writeback,
  // 8 branch, 9 immediate execute, 10 immediate writeback, 11 jump
  function automatic logic [2:0] functAlu(input logic [5:0] fn);
    case (fn)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  // {pcW,irW,regW,memW,br,iOrD,srcA,srcB[2],pcSrc[2],regDst,memToReg,aluCtl[3]}
  function automatic logic [15:0] expVec(input int st, input logic [5:0] fn);
    case (st)
      0:  return 16'b1100000_01_00_00_010;
      1:  return 16'b0000000_11_00_00_010;
      2:  return 16'b0000001_10_00_00_010;
      3:  return 16'b0000010_00_00_00_010;
      4:  return 16'b0010000_00_00_01_010;
      5:  return 16'b0001010_00_00_00_010;
      6:  return {13'b0000001_00_00_00, functAlu(fn)};
      7:  return 16'b0010000_00_00_10_010;
      8:  return 16'b0000101_00_01_00_110;
      9:  return 16'b0000001_10_00_00_010;
      10: return 16'b0010000_00_00_00_010;
      default: return 16'b1000000_00_10_00_010;
    endcase
  endfunction

  function automatic int seqLen(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000, 6'b001000: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int seqState(input logic [5:0] op, input int i);
    if (i == 0) return 0;
    if (i == 1) return 1;
    case (op)
      6'b100011: return (i == 2) ? 2 : (i == 3) ? 3 : 4;
      6'b101011: return (i == 2) ? 2 : 5;
      6'b000000: return (i == 2) ? 6 : 7;
      6'b000100: return 8;
      6'b001000: return (i == 2) ? 9 : 10;
      default:   return 11;
    endcase
  endfunction

  function automatic string opTag(input logic [5:0] op);
    case (op)
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000000: return "R6";
      6'b000100: return "R7";
      6'b001000: return "R8";
      6'b000010: return "R9";
      default:   return "R10";
    endcase
  endfunction

  function automatic string stTag(input int st, input logic [5:0] op);
    case (st)
      1: return "R3 R12";
      3: return "R4 R12";
      6: return "R6 R11";
      8: return "R7 R11";
      default: return opTag(op);
    endcase
  endfunction

  task automatic check(input int st, input logic [5:0] fn, input string tag);
    logic [15:0] act, exp;
    act = {pcWrite, irWrite, regWrite, memWrite, branch, iOrD, aluSrcA,
           aluSrcB, pcSrc, regDst, memToReg, aluCtl};
    exp = expVec(st, fn);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d op=%b fn=%b actual=%b expected=%b",
               tag, st, opcode, fn, act, exp);
    end
  endtask

  // entered mid fetch cycle; leaves mid fetch cycle of the next instruction
  task automatic doInstr(input logic [5:0] op, input logic [5:0] fn);
    int len;
    opcode = op;
    funct = fn;
    len = seqLen(op);
    #1;
    check(0, fn, "R2");
    for (int i = 1; i < len; i++) begin
      @(negedge clk); #1;
      check(seqState(op, i), fn, stTag(seqState(op, i), op));
    end
    @(negedge clk); #1;
    check(0, fn, opTag(op));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(0, 6'd0, "R1");
    rst = 1'b0;
    #1;
    check(0, 6'd0, "R1");
    // R6 R11: every function code through register-register path
    for (int f = 0; f < 64; f++) doInstr(6'b000000, f[5:0]);
    // R3 R10: every opcode
    for (int o = 0; o < 64; o++) doInstr(o[5:0], 6'b100100);
    // R1: synchronous reset in the middle of a load
    opcode = 6'b100011;
    @(negedge clk); @(negedge clk); @(negedge clk);
    #1;
    check(3, 6'd0, "R4");
    rst = 1'b1;
    @(negedge clk); #1;
    check(0, 6'd0, "R1");
    rst = 1'b0;
    @(negedge clk); #1;
    check(1, 6'd0, "R1");
    @(negedge clk); #1;
    check(2, 6'd0, "R1");
    repeat (3) @(negedge clk);
    #1;
    doInstr(6'b000010, 6'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule